// File: doc/BRIEF.md
# Page-Write EEPROM Controller with Write-Status Polling

This block models the control side of a byte-alterable nonvolatile memory. The memory sits behind a parallel bus with active-low chip-enable, output-enable and write-enable strobes, and every bus input is sampled on a synchronous clock. Write strobes that share one page are collected into a 128-byte page buffer. When the bus stays quiet for a set load window, or when a write names a different page, a self-timed programming cycle starts. That cycle copies the buffered bytes into a register-model storage array, one byte per clock, and then holds busy for the rest of a fixed cycle count. A new byte simply replaces the old one; no erase step is needed.

While the programming cycle runs, a read does not return array contents. It returns a status word that software polls to find the end of the write. Bit 7 of the status word is the inverse of bit 7 of the last byte written. Bit 6 changes on every new read access. When the cycle finishes, reads return true array data again. The full-size part uses 15 address bits (32768 bytes). The address width is a parameter, so smaller arrays can be built.

The controller is a four-state machine:
- States:
  - `S_IDLE`: no page load is pending.
  - `S_LOAD`: a page load is in progress.
  - `S_COMMIT`: buffered bytes are copied into the array, one byte per clock.
  - `S_HOLD`: the cycle-count wait after the copy.
- Transitions:
  - `S_IDLE` to `S_LOAD`: on the first accepted write.
  - `S_LOAD` to `S_LOAD`: a write to the same page restarts the window.
  - `S_LOAD` to `S_COMMIT`: when the load window expires or a write names another page.
  - `S_COMMIT` to `S_HOLD`: after the last buffer slot is copied.
  - `S_HOLD` to `S_IDLE`: when the cycle count completes.

Top module: `pgw_eeprom_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `dout_en` is 0.
- R2: When `ce_n`=0, `oe_n`=0 and `we_n`=1 are held outside a programming cycle, `dout_en` is 1 on the following cycle and `dout` shows the array byte at `addr`. When `ce_n` or `oe_n` is high, `dout_en` is 0.
- R3: A write is the falling edge of (`ce_n`=0 and `we_n`=0). It captures `addr` and `din` into the page buffer only. Reads during loading still return the old array contents. After the cycle, the new byte has replaced the old one.
- R4: The page is `addr[ADDR_W-1:7]` and the byte offset is `addr[6:0]`. `busy` rises exactly `LOAD_WIN` cycles after the last accepted write edge. Each write to the same page restarts that window.
- R5: During loading, a write whose page bits differ from the loaded page starts the programming cycle on the next cycle. That write is discarded.
- R6: `busy` stays high for exactly `WR_CYCLES` consecutive cycles (`WR_CYCLES` must exceed 128).
- R7: Write strobes while `busy` is high change neither the array nor the page buffer, and they start no new cycle.
- R8: While `busy` is high, `dout[7]` of a read is the inverse of bit 7 of the last accepted write byte. After the cycle ends, the same address reads back the true data.
- R9: While `busy` is high, `dout[6]` takes the opposite value on each new read access, and `dout[5:0]` is 0. After the cycle ends, repeated reads return the same value.
- R10: Only the buffered offsets of the page are written. Other bytes of the same page keep their previous contents.
- R11: Repeated writes to one offset within a page load leave the last written byte in the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address; top bits select the page, low 7 bits the offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or, during a cycle, the status word |
| dout_en | output | 1 | High when the data bus would be driven; low stands for high impedance |
| busy | output | 1 | High during the self-timed programming cycle |

## Verification
The bench builds the block with the following parameters:
- `ADDR_W`=11, which gives sixteen pages, so page-change cases and several independent pages are cheap to reach.
- `LOAD_WIN`=20, which lets a test write a whole 128-byte page, restart the window just before it expires, and check busy exactly on the expiry edge.
- `WR_CYCLES`=160, just above the 128-cycle copy phase, which keeps each cycle short while still leaving room for several status reads during busy and for writes that must be ignored.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOAD   = 2'd1,
        S_COMMIT = 2'd2,
        S_HOLD   = 2'd3
    } pgw_state_e;

    localparam int unsigned PGW_DATA_W = 8;

endpackage

// File: rtl/pgw_bus.sv
module pgw_bus #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_stb,
    output logic              rd_start,
    output logic              rd_live,
    output logic [ADDR_W-1:0] rd_addr
);

    logic we_act;
    logic rd_act;
    logic we_q;
    logic rd_q;

    assign we_act = ~ce_n & ~we_n;
    assign rd_act = ~ce_n & ~oe_n & we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            rd_q    <= 1'b0;
            rd_addr <= '0;
        end else begin
            we_q <= we_act;
            rd_q <= rd_act;
            if (rd_act) begin
                rd_addr <= addr;
            end
        end
    end

    assign wr_stb   = we_act & ~we_q;
    assign rd_start = rd_act & ~rd_q;
    assign rd_live  = rd_q;

    // R2: a write strobe never leaves the data bus enabled on the next cycle
    a_r2_no_drive_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_act) |=> !rd_live);

endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int unsigned PAGE_W    = 7,
    parameter int unsigned PG_W      = 4,
    parameter int unsigned LOAD_WIN  = 32,
    parameter int unsigned WR_CYCLES = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [PG_W-1:0]   wr_page,
    output logic              accept,
    output logic              busy,
    output logic              commit_go,
    output logic              buf_clear,
    output logic [PAGE_W-1:0] commit_off,
    output logic [PG_W-1:0]   page_q
);

    localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
    localparam int unsigned WIN_W      = $clog2(LOAD_WIN + 1);
    localparam int unsigned CYC_W      = $clog2(WR_CYCLES + 1);
    localparam logic [WIN_W-1:0] WIN_LAST  = WIN_W'(LOAD_WIN - 1);
    localparam logic [CYC_W-1:0] COPY_LAST = CYC_W'(PAGE_BYTES - 1);
    localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(WR_CYCLES - 1);

    pgw_state_e       state;
    pgw_state_e       nxt;
    logic [WIN_W-1:0] win;
    logic [CYC_W-1:0] cyc;
    logic             same_pg;
    logic             pg_miss;

    assign same_pg = (wr_page == page_q);
    assign pg_miss = (state == S_LOAD) && wr_stb && !same_pg;
    assign accept  = wr_stb && ((state == S_IDLE) || ((state == S_LOAD) && same_pg));

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept) nxt = S_LOAD;
            end
            S_LOAD: begin
                if (pg_miss)              nxt = S_COMMIT;
                else if (accept)          nxt = S_LOAD;
                else if (win == WIN_LAST) nxt = S_COMMIT;
            end
            S_COMMIT: begin
                if (cyc == COPY_LAST) nxt = S_HOLD;
            end
            S_HOLD: begin
                if (cyc == CYC_LAST) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win    <= '0;
            cyc    <= '0;
            page_q <= '0;
        end else begin
            if (accept)                win <= '0;
            else if (state == S_LOAD)  win <= win + 1'b1;
            if (state == S_COMMIT || state == S_HOLD) cyc <= cyc + 1'b1;
            else                                      cyc <= '0;
            if (accept && state == S_IDLE) page_q <= wr_page;
        end
    end

    always_comb begin
        busy       = 1'b0;
        commit_go  = 1'b0;
        buf_clear  = 1'b0;
        commit_off = cyc[PAGE_W-1:0];
        unique case (state)
            S_IDLE, S_LOAD: begin
                busy = 1'b0;
            end
            S_COMMIT: begin
                busy      = 1'b1;
                commit_go = 1'b1;
                buf_clear = (cyc == COPY_LAST);
            end
            S_HOLD: begin
                busy = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // R5: a foreign-page write during loading starts the cycle at once
    a_r5_miss_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pg_miss |=> busy);

    // R7: nothing is accepted into the buffer while the cycle runs
    a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
    parameter int unsigned PAGE_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clear,
    input  logic [PAGE_W-1:0] rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int unsigned PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_vld;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_off == PAGE_W'(g));

        always_ff @(posedge clk) begin
            if (hit) slot_data[g] <= wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     slot_vld[g] <= 1'b0;
            else if (clear) slot_vld[g] <= 1'b0;
            else if (hit)   slot_vld[g] <= 1'b1;
        end
    end

    assign rd_data  = slot_data[rd_off];
    assign rd_valid = slot_vld[rd_off];

    // R3: loading and clearing never coincide
    a_r3_no_load_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !wr_en);

endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/pgw_eeprom_ctrl.sv
module pgw_eeprom_ctrl
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned PAGE_W    = 7,
    parameter int unsigned LOAD_WIN  = 32,
    parameter int unsigned WR_CYCLES = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy
);

    localparam int unsigned PG_W = ADDR_W - PAGE_W;
    localparam int unsigned DW   = PGW_DATA_W;

    logic              wr_stb;
    logic              rd_start;
    logic              rd_live;
    logic [ADDR_W-1:0] rd_addr;
    logic              accept;
    logic              commit_go;
    logic              buf_clear;
    logic [PAGE_W-1:0] commit_off;
    logic [PG_W-1:0]   page_q;
    logic [DW-1:0]     buf_data;
    logic              buf_valid;
    logic              arr_we;
    logic [DW-1:0]     arr_rdata;
    logic [DW-1:0]     last_byte;
    logic              tog;

    pgw_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .wr_stb   (wr_stb),
        .rd_start (rd_start),
        .rd_live  (rd_live),
        .rd_addr  (rd_addr)
    );

    pgw_seq #(
        .PAGE_W    (PAGE_W),
        .PG_W      (PG_W),
        .LOAD_WIN  (LOAD_WIN),
        .WR_CYCLES (WR_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_page    (addr[ADDR_W-1:PAGE_W]),
        .accept     (accept),
        .busy       (busy),
        .commit_go  (commit_go),
        .buf_clear  (buf_clear),
        .commit_off (commit_off),
        .page_q     (page_q)
    );

    pgw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_off   (addr[PAGE_W-1:0]),
        .wr_data  (din),
        .clear    (buf_clear),
        .rd_off   (commit_off),
        .rd_data  (buf_data),
        .rd_valid (buf_valid)
    );

    assign arr_we = commit_go && buf_valid;

    pgw_array #(.ADDR_W(ADDR_W), .DATA_W(DW)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .waddr ({page_q, commit_off}),
        .wdata (buf_data),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_byte <= '0;
            tog       <= 1'b0;
        end else begin
            if (accept)            last_byte <= din;
            if (rd_start && busy)  tog <= ~tog;
        end
    end

    always_comb begin
        dout_en = rd_live;
        if (busy) dout = {~last_byte[7], tog, 6'b0};
        else      dout = arr_rdata;
    end

    // Checker state for the window and cycle-length properties
    logic [15:0] chk_run;
    logic [15:0] chk_gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_run <= '0;
            chk_gap <= '0;
        end else begin
            chk_run <= busy ? chk_run + 16'd1 : 16'd0;
            if (accept)                 chk_gap <= '0;
            else if (chk_gap != 16'hFFFF) chk_gap <= chk_gap + 16'd1;
        end
    end

    // R6: every cycle lasts exactly WR_CYCLES clocks
    a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_run == 16'(WR_CYCLES)));

    // R4: window expiry or a page change is the only way a cycle starts
    a_r4_window_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wr_stb) || ($past(chk_gap) == 16'(LOAD_WIN - 1))));

    // R3: the array is written only inside the programming cycle
    a_r3_array_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

endmodule

// File: tb/pgw_eeprom_ctrl_test.sv
module pgw_eeprom_ctrl_test;

    localparam int AW = 11;
    localparam int LW = 20;
    localparam int WC = 160;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pgw_eeprom_ctrl #(
        .ADDR_W    (AW),
        .PAGE_W    (7),
        .LOAD_WIN  (LW),
        .WR_CYCLES (WC)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en),
        .busy    (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ad(input int pg, input int off);
        return AW'(pg * 128 + off);
    endfunction

    function automatic logic [7:0] pat(input int off);
        return 8'(off) ^ 8'h5A;
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic e);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        d = dout; e = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_busy();
        while (!busy) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(dout_en == 1'b0, "R1 dout_en after reset", dout_en, 0);
    endtask

    task automatic t_preload();
        logic [7:0] d; logic e;
        for (int i = 0; i < 128; i++) wr(ad(3, i), pat(i));
        wait_busy();
        wait_idle();
        rd(ad(3, 0), d, e);
        chk(e == 1'b1, "R2 dout_en on read", e, 1);
        chk(d == pat(0), "R2 read offset 0", d, pat(0));
        rd(ad(3, 77), d, e);
        chk(d == pat(77), "R3 full page offset 77", d, pat(77));
        rd(ad(3, 127), d, e);
        chk(d == pat(127), "R3 full page offset 127", d, pat(127));
    endtask

    task automatic t_gate();
        @(negedge clk); addr = ad(3, 5); ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(dout_en == 1'b0, "R2 ce_n high no drive", dout_en, 0);
        ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(dout_en == 1'b0, "R2 oe_n high no drive", dout_en, 0);
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_window();
        int n; bit early;
        early = 1'b0;
        wr(ad(5, 10), 8'hC3);
        for (int k = 1; k < LW; k++) begin
            @(negedge clk);
            if (busy) early = 1'b1;
        end
        chk(!early, "R4 busy before window end", early, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R4 busy at window end", busy, 1);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == WC, "R6 busy length", n, WC);
    endtask

    task automatic t_restart();
        logic [7:0] d; logic e;
        wr(ad(6, 1), 8'h11);
        repeat (LW - 5) @(negedge clk);
        wr(ad(6, 2), 8'h22);
        wr(ad(6, 1), 8'h33);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R4 window restarted", busy, 0);
        wait_busy();
        wait_idle();
        rd(ad(6, 1), d, e);
        chk(d == 8'h33, "R11 last write wins", d, 8'h33);
        rd(ad(6, 2), d, e);
        chk(d == 8'h22, "R4 second byte of load", d, 8'h22);
    endtask

    task automatic t_poll();
        logic [7:0] d1, d2, d3, d; logic e;
        wr(ad(7, 4), 8'hA6);
        wait_busy();
        rd(ad(3, 0), d1, e);
        chk(e == 1'b1, "R8 dout_en during busy", e, 1);
        chk(d1[7] == 1'b0, "R8 inverted bit7 (last=1)", d1[7], 0);
        chk(d1[5:0] == 6'd0, "R9 low bits zero", d1[5:0], 0);
        rd(ad(3, 0), d2, e);
        chk(d2[6] != d1[6], "R9 bit6 toggles", d2[6], !d1[6]);
        rd(ad(7, 4), d3, e);
        chk(d3[6] == d1[6], "R9 bit6 toggles back", d3[6], d1[6]);
        wait_idle();
        rd(ad(7, 4), d, e);
        chk(d == 8'hA6, "R8 true data after cycle", d, 8'hA6);
        rd(ad(7, 4), d2, e);
        chk(d2 == d, "R9 no toggle after cycle", d2, d);
        wr(ad(7, 5), 8'h15);
        wait_busy();
        rd(ad(7, 5), d1, e);
        chk(d1[7] == 1'b1, "R8 inverted bit7 (last=0)", d1[7], 1);
        wait_idle();
    endtask

    task automatic t_page_change();
        logic [7:0] d; logic e;
        wr(ad(8, 0), 8'h44);
        wr(ad(3, 9), 8'hEE);
        chk(busy == 1'b1, "R5 page change starts cycle", busy, 1);
        wait_idle();
        rd(ad(8, 0), d, e);
        chk(d == 8'h44, "R5 pending page committed", d, 8'h44);
        rd(ad(3, 9), d, e);
        chk(d == pat(9), "R5 foreign write dropped", d, pat(9));
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d; logic e; bit seen;
        wr(ad(9, 0), 8'h10);
        wait_busy();
        wr(ad(3, 20), 8'h00);
        wr(ad(9, 0), 8'h99);
        wait_idle();
        seen = 1'b0;
        repeat (LW + 5) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        chk(!seen, "R7 no cycle from ignored writes", seen, 0);
        rd(ad(3, 20), d, e);
        chk(d == pat(20), "R7 array untouched", d, pat(20));
        rd(ad(9, 0), d, e);
        chk(d == 8'h10, "R7 buffer untouched", d, 8'h10);
    endtask

    task automatic t_partial();
        logic [7:0] d; logic e;
        wr(ad(3, 50), 8'h01);
        rd(ad(3, 50), d, e);
        chk(d == pat(50), "R3 old data while loading", d, pat(50));
        wait_busy();
        wait_idle();
        rd(ad(3, 50), d, e);
        chk(d == 8'h01, "R3 byte replaced", d, 8'h01);
        rd(ad(3, 49), d, e);
        chk(d == pat(49), "R10 neighbour below kept", d, pat(49));
        rd(ad(3, 51), d, e);
        chk(d == pat(51), "R10 neighbour above kept", d, pat(51));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_preload();
        t_gate();
        t_window();
        t_restart();
        t_poll();
        t_page_change();
        t_busy_ignore();
        t_partial();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule